// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block pulls a configuration image out of an external serial flash. Once reset is released it lowers the flash select and begins generating the serial clock itself. It shifts out a read opcode and a zero start address, and from then on it assembles every eight returned bits into a byte. Each byte goes to a downstream consumer together with a single-cycle strobe in the system clock domain.

The serial clock is a divided copy of the system clock, and each half period lasts a programmable number of system cycles. A slow default rate applies after reset. One fixed byte position in the image may carry a new half-period value, and that value retunes the clock for the rest of the load. The change waits for a phase boundary, so no clock pulse is ever cut short.

When the external done input goes high, the loader stops collecting bytes. It keeps clocking for a fixed number of further cycles, then parks the clock low, deselects the flash and raises its finished flag.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is asserted, cs_n_o is 1 and sclk_o, mosi_o, byte_vld_o and finished_o are 0. Whenever cs_n_o is 1, sclk_o is 0.
- R2: After reset, cs_n_o goes low and the first 32 serial clock cycles carry opcode 0x03 followed by 24 zero address bits, most significant bit first. mosi_o changes only in the system cycle in which sclk_o rises.
- R3: Until a new rate is loaded, each high phase and each low phase of sclk_o lasts DIV_DEFAULT system cycles (default 25, which is 2.5 MHz from a 125 MHz clock).
- R4: From serial clock cycle 33 onward, miso_i is sampled at each falling edge of sclk_o, most significant bit first. Each completed byte appears on byte_o with byte_vld_o high for exactly one system cycle.
- R5: If data byte number DIV_BYTE_IDX (counting from 0 at the first data byte, default 2) is nonzero, it becomes the new half period. The new value first applies to the high phase that follows the low phase after that byte's last falling edge. All earlier phases keep the old length.
- R6: A zero value in the rate byte position is ignored, and the half period stays unchanged.
- R7: Once done_i is seen high during the data phase, no further byte is delivered. Exactly TRAIL_CYCLES (100 to 500, default 100) further falling edges of sclk_o occur, and a fall in the very cycle where done_i is first sampled counts among them.
- R8: After the last trailing falling edge, sclk_o stays low, cs_n_o is 1 and finished_o is 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| miso_i | input | 1 | Serial data returned by the flash |
| done_i | input | 1 | External configuration-complete indication |
| sclk_o | output | 1 | Generated serial clock |
| cs_n_o | output | 1 | Flash select, active low |
| mosi_o | output | 1 | Serial command data toward the flash |
| byte_o | output | BYTE_W | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| finished_o | output | 1 | Load sequence complete |

## Verification
The hardest case to reach from the ports is the rate switch. A flash model in the bench answers on each rising edge with an image whose rate byte is computed in the bench. Each high phase of the clock is classed as old or new by whether the rate byte had already been delivered when that phase began, and every phase length is compared to the matching expected value. A second load with a zero rate byte shows that the rate is left alone. The trailing window is measured by counting clock falls from the first cycle in which the loader can see done, then watching that no further falls or bytes appear once finished is raised.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_TRAIL,
    ST_FINISH
  } boot_st_e;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] READ_OP = 8'h03;
endpackage

// File: rtl/spi_boot_clkgen.sv
module spi_boot_clkgen #(
  parameter int DIV_W       = 8,
  parameter int DIV_DEFAULT = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] HALF_RST = DIV_W'(DIV_DEFAULT);

  logic [DIV_W-1:0] cnt_q, cnt_d, half_q, half_d, pend_q, pend_d;
  logic             pend_v_q, pend_v_d, sclk_q, sclk_d, tick;

  assign tick   = run_i && (cnt_q == half_q - 1'b1);
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_comb begin
    cnt_d    = cnt_q;
    sclk_d   = sclk_q;
    half_d   = half_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (load_i) begin
      pend_d   = load_val_i;
      pend_v_d = 1'b1;
    end else if (tick && pend_v_q) begin
      half_d   = pend_q;
      pend_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sclk_q   <= 1'b0;
      half_q   <= HALF_RST;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      sclk_q   <= sclk_d;
      half_q   <= half_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  // R3
  half_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0);

  // R5
  half_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(half_q) |-> $past(tick));
endmodule

// File: rtl/spi_boot_rx.sv
module spi_boot_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic              miso_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST = BCW'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (clr_i) begin
      sh_d  = '0;
      bit_d = '0;
    end else if (smp_i) begin
      sh_d  = {sh_q[BYTE_W-3:0], miso_i};
      bit_d = (bit_q == LAST) ? '0 : bit_q + 1'b1;
      if (bit_q == LAST) begin
        vld_d  = 1'b1;
        byte_d = {sh_q, miso_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;

  // R4
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int DIV_DEFAULT  = 25,
  parameter int TRAIL_CYCLES = 100,
  parameter int DIV_BYTE_IDX = 2,
  parameter int BYTE_W       = 8,
  parameter int ADDR_W       = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miso_i,
  input  logic              done_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              finished_o
);
  localparam int CMD_BITS = OP_W + ADDR_W;
  localparam int CCW      = $clog2(CMD_BITS + 1);
  localparam int TCW      = $clog2(TRAIL_CYCLES + 1);
  localparam int BIW      = $clog2(DIV_BYTE_IDX + 2);
  localparam logic [CMD_BITS-1:0] CMD_WORD = {READ_OP, {ADDR_W{1'b0}}};

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  boot_st_e            st_q, st_d;
  logic [CMD_BITS-1:0] cmd_q, cmd_d;
  logic [CCW-1:0]      ccnt_q, ccnt_d;
  logic [TCW-1:0]      tcnt_q, tcnt_d;
  logic [BIW-1:0]      bidx_q, bidx_d;
  logic                mosi_q, mosi_d, cs_n_q, cs_n_d, fin_q, fin_d;
  logic                run, rise, fall, smp, clr, load;
  logic [BYTE_W-1:0]   rx_byte;
  logic                rx_vld;

  assign run  = (st_q == ST_CMD) || (st_q == ST_DATA) || (st_q == ST_TRAIL);
  assign smp  = fall && (st_q == ST_DATA) && !done_i;
  assign clr  = (st_q == ST_IDLE);
  assign load = rx_vld && (bidx_q == BIW'(DIV_BYTE_IDX)) && (rx_byte != '0);

  spi_boot_clkgen #(.DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)) clkgen_i (
    .clk_i(clk_i), .rst_ni(rst_s), .run_i(run), .load_i(load),
    .load_val_i(DIV_W'(rx_byte)), .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  spi_boot_rx #(.BYTE_W(BYTE_W)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_s), .clr_i(clr), .smp_i(smp), .miso_i(miso_i),
    .byte_o(rx_byte), .vld_o(rx_vld)
  );

  always_comb begin
    st_d   = st_q;
    cmd_d  = cmd_q;
    ccnt_d = ccnt_q;
    tcnt_d = tcnt_q;
    mosi_d = mosi_q;
    bidx_d = bidx_q;
    if (rx_vld && (bidx_q != BIW'(DIV_BYTE_IDX + 1))) bidx_d = bidx_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        st_d   = ST_CMD;
        cmd_d  = CMD_WORD;
        ccnt_d = '0;
      end
      ST_CMD: begin
        if (rise) begin
          mosi_d = cmd_q[CMD_BITS-1];
          cmd_d  = {cmd_q[CMD_BITS-2:0], 1'b0};
          ccnt_d = ccnt_q + 1'b1;
        end
        if (fall && (ccnt_q == CCW'(CMD_BITS))) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (done_i) begin
          st_d   = ST_TRAIL;
          tcnt_d = fall ? TCW'(1) : '0;
        end
      end
      ST_TRAIL: begin
        if (fall) begin
          if (tcnt_q == TCW'(TRAIL_CYCLES - 1)) st_d = ST_FINISH;
          else                                  tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: st_d = ST_FINISH;
    endcase
    cs_n_d = !((st_d == ST_CMD) || (st_d == ST_DATA) || (st_d == ST_TRAIL));
    fin_d  = (st_d == ST_FINISH);
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      ccnt_q <= '0;
      tcnt_q <= '0;
      bidx_q <= '0;
      mosi_q <= 1'b0;
      cs_n_q <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      ccnt_q <= ccnt_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      mosi_q <= mosi_d;
      cs_n_q <= cs_n_d;
      fin_q  <= fin_d;
    end
  end

  assign mosi_o     = mosi_q;
  assign cs_n_o     = cs_n_q;
  assign finished_o = fin_q;
  assign byte_o     = rx_byte;
  assign byte_vld_o = rx_vld;

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    cs_n_o |-> !sclk_o);

  // R2
  mosi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    !$stable(mosi_o) |-> $rose(sclk_o));

  // R8
  fin_park_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    finished_o |=> finished_o && cs_n_o && !sclk_o);

  // R7
  trail_nobyte_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (st_q == ST_TRAIL) && $past(st_q == ST_TRAIL) |-> !byte_vld_o);
endmodule

// File: tb/spi_boot_loader_tb_top.sv
module spi_boot_loader_tb_top;
  localparam int HALF_DEF = 25;
  localparam int TRAIL    = 100;
  localparam int DIV_IDX  = 2;

  logic clk, rst_n, miso, done;
  logic sclk_o, cs_n_o, mosi_o, byte_vld_o, finished_o;
  logic [7:0] byte_o;

  int n_tests, n_fail;
  int fcyc;
  logic [7:0] div_val;
  int exp_new;
  logic prev_sclk, prev_fin;
  logic [31:0] cmd_cap;
  int cmd_n, hcnt, n_new, bad_new, n_old, bad_old, rx_cnt, extra_vld;
  int trail_falls, post_fin_falls;
  bit hi_new, trail_on;

  spi_boot_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .miso_i(miso), .done_i(done),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .finished_o(finished_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(int n);
    if (n == DIV_IDX) return div_val;
    return 8'((n * 37 + 5) % 256);
  endfunction

  // flash model: changes data on each rising edge, from clock cycle 32 on
  always @(posedge sclk_o) begin
    if (fcyc >= 32) begin
      int k;
      logic [7:0] bb;
      k    = fcyc - 32;
      bb   = byte_of(k / 8);
      miso = bb[7 - (k % 8)];
    end
    fcyc++;
  end

  always @(negedge clk) begin
    bit fell, rose;
    fell = prev_sclk && !sclk_o;
    rose = !prev_sclk && sclk_o;
    if (!cs_n_o && fell && cmd_n < 32) begin
      cmd_cap = {cmd_cap[30:0], mosi_o};
      cmd_n++;
    end
    if (sclk_o) begin
      if (rose) begin
        hcnt   = 1;
        hi_new = (rx_cnt > DIV_IDX);
      end else hcnt++;
    end else if (fell) begin
      if (hi_new) begin
        n_new++;
        if (hcnt != exp_new) bad_new++;
      end else begin
        n_old++;
        if (hcnt != HALF_DEF) bad_old++;
      end
    end
    if (byte_vld_o) begin
      if (trail_on) extra_vld++;
      else begin
        chk(byte_o == byte_of(rx_cnt), "R4", "received byte", byte_o, byte_of(rx_cnt));
        rx_cnt++;
      end
    end
    if (trail_on && fell && !prev_fin) trail_falls++;
    if (fell && prev_fin) post_fin_falls++;
    if (done && !trail_on) trail_on = 1'b1;
    prev_sclk = sclk_o;
    prev_fin  = finished_o;
  end

  task automatic run_load(input logic [7:0] dv, input int nb, input int exp_half);
    rst_n = 1'b0;
    done  = 1'b0;
    miso  = 1'b0;
    div_val = dv;
    exp_new = exp_half;
    fcyc = 0; cmd_cap = '0; cmd_n = 0; hcnt = 0; n_new = 0; bad_new = 0;
    n_old = 0; bad_old = 0; rx_cnt = 0; extra_vld = 0; trail_falls = 0;
    post_fin_falls = 0; hi_new = 1'b0; trail_on = 1'b0;
    prev_sclk = 1'b0; prev_fin = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1", "cs_n in reset", cs_n_o, 1);
    chk({sclk_o, mosi_o, byte_vld_o, finished_o} == 4'b0, "R1", "outputs in reset",
        {sclk_o, mosi_o, byte_vld_o, finished_o}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    wait (rx_cnt == nb);
    // R2 command word
    chk(cmd_n == 32 && cmd_cap == 32'h0300_0000, "R2", "command word", cmd_cap, 32'h0300_0000);
    @(posedge clk);
    #1 done = 1'b1;
    wait (finished_o);
    repeat (200) @(negedge clk);
    // R3 default half period
    chk(n_old > 32 && bad_old == 0, "R3", "old-rate phases wrong", bad_old, 0);
    // R5 / R6 half period after the rate byte
    chk(n_new > 0 && bad_new == 0, (dv != 0) ? "R5" : "R6", "post-rate phases wrong",
        bad_new, 0);
    // R7 trailing falls, no bytes after done
    chk(trail_falls == TRAIL, "R7", "trailing falls", trail_falls, TRAIL);
    chk(extra_vld == 0, "R7", "bytes after done", extra_vld, 0);
    // R8 parked state
    chk(finished_o && cs_n_o && !sclk_o, "R8", "parked outputs",
        {finished_o, cs_n_o, sclk_o}, 3'b110);
    chk(post_fin_falls == 0, "R8", "clock after finish", post_fin_falls, 0);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    run_load(8'd3, 10, 3);
    run_load(8'd0, 5, HALF_DEF);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule